// File: doc/BRIEF.md
# Interleaved I/Q Word Demultiplexer

This block is the receive side of a narrow parallel sample port. An upstream source places in-phase and quadrature words one after the other on a single 14-bit bus. The block drives the word clock that paces that source, captures one word on each rising edge of it, and joins an in-phase word with the quadrature word that follows it. The pair goes to the internal datapath as two side-by-side fields with a one-cycle valid strobe, so samples arrive at half the word rate.

Everything runs from one core clock. The outgoing word clock is a divided copy of that clock, and a capture happens on the core edge at which the word clock goes high. A transmit-enable input frames each burst. While it is low, the pairing restarts, any unpaired word is dropped, and the sample outputs carry zeros. Then the first word of the next burst is always taken as in-phase. This is the port used in the default quadrature modulation operating mode.

Top module: `iq_port_rx`

## Requirements
- R1: While synchronous reset is asserted, and right after it, `dataClkOut` is 0, `sampleValid` is 0, and `sampleI` and `sampleQ` are all zeros.
- R2: `dataClkOut` is a square wave. It changes level once every HALF_PERIOD core clock edges, starting with the edge HALF_PERIOD after reset release, so one full period is 2*HALF_PERIOD core cycles. It runs whatever the level of `txEnable`.
- R3: A word is captured on the core clock edge at which `dataClkOut` goes from 0 to 1. The value on `wordIn` at that edge is the value taken.
- R4: With `txEnable` high, captured words alternate. The first word after `txEnable` was low (or after reset) is in-phase, the next is quadrature, then in-phase again, and so on.
- R5: On the edge that captures a quadrature word, `sampleI` takes the stored in-phase word and `sampleQ` takes the quadrature word. `sampleValid` is 1 for exactly the one core cycle that follows that edge.
- R6: In a continuous burst, `sampleValid` pulses exactly once for every two captured words.
- R7: Any core clock edge with `txEnable` low discards a stored in-phase word that has no partner yet. On that edge, `sampleI` and `sampleQ` are cleared to zero and `sampleValid` is cleared to 0.
- R8: Words on `wordIn` while `txEnable` is low have no effect. The outputs stay at zero, and no such word is ever paired into a later sample.
- R9: Between valid strobes, with `txEnable` high, `sampleI` and `sampleQ` keep the last pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| txEnable | input | 1 | Burst framing; low flushes the pairing and zeroes the outputs |
| wordIn | input | WORD_W (14) | Interleaved I/Q word bus |
| dataClkOut | output | 1 | Word clock driven to the upstream source |
| sampleI | output | WORD_W (14) | In-phase half of the last complete sample |
| sampleQ | output | WORD_W (14) | Quadrature half of the last complete sample |
| sampleValid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bench runs the block with a divider of two, so that captures fall only on some core edges. First a counting ramp is applied. A ramp shows at once whether the right edge is captured and whether the in-phase and quadrature words are swapped or taken from neighbouring words. Bursts then end after different numbers of cycles, so that `txEnable` drops both in the middle of a pair and between pairs. This separates a correct flush from one that leaves the pairing phase behind. A long stretch with enable low and random data checks that those words are ignored. Long random bursts follow, to check the strobe rate and that the outputs hold their values between strobes.

// File: rtl/iq_port_pkg.sv
package iq_port_pkg;

  // Strobes passed from the control to the datapath each core cycle
  typedef struct packed {
    logic captureI;   // take the bus word as in-phase
    logic captureQ;   // take the bus word as quadrature and complete the pair
    logic flush;      // burst inactive: drop partial pair, zero outputs
  } ctlStrobes_t;

endpackage

// File: rtl/iq_port_ctrl.sv
module iq_port_ctrl
  import iq_port_pkg::*;
#(
  parameter int HALF_PERIOD = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        txEnable,
  output logic        dataClkOut,
  output ctlStrobes_t strobes
);

  localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] divCnt;
  logic             dataClkReg;
  logic             phaseQ;
  logic             atTerminal;
  logic             riseTick;

  assign atTerminal = (divCnt == CNT_LAST);
  assign riseTick   = atTerminal && !dataClkReg;

  // Word clock divider: toggles on each terminal count
  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt     <= '0;
      dataClkReg <= 1'b0;
    end else begin
      if (atTerminal) begin
        divCnt     <= '0;
        dataClkReg <= !dataClkReg;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // Pairing phase: 0 expects in-phase, 1 expects quadrature
  always_ff @(posedge clk) begin
    if (rst || !txEnable) begin
      phaseQ <= 1'b0;
    end else if (riseTick) begin
      phaseQ <= !phaseQ;
    end
  end

  always_comb begin
    strobes.flush    = !txEnable;
    strobes.captureI = riseTick && txEnable && !phaseQ;
    strobes.captureQ = riseTick && txEnable && phaseQ;
  end

  assign dataClkOut = dataClkReg;

  // R2
  clk_steady_chk: assert property (@(posedge clk) disable iff (rst)
    !atTerminal |=> $stable(dataClkOut));

  // R4
  pair_order_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.captureI |=> phaseQ);

  // R3
  capture_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.captureI || strobes.captureQ) |=> $rose(dataClkOut));

endmodule

// File: rtl/iq_port_dpath.sv
module iq_port_dpath
  import iq_port_pkg::*;
#(
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       strobes,
  input  logic [WORD_W-1:0] wordIn,
  output logic [WORD_W-1:0] sampleI,
  output logic [WORD_W-1:0] sampleQ,
  output logic              sampleValid
);

  logic [WORD_W-1:0] holdI;

  always_ff @(posedge clk) begin
    if (rst || strobes.flush) begin
      holdI       <= '0;
      sampleI     <= '0;
      sampleQ     <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobes.captureQ;
      if (strobes.captureI) begin
        holdI <= wordIn;
      end
      if (strobes.captureQ) begin
        sampleI <= holdI;
        sampleQ <= wordIn;
      end
    end
  end

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> !sampleValid);

  // R7
  flush_zero_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.flush |=> (sampleI == '0 && sampleQ == '0 && !sampleValid));

  // R9
  hold_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobes.captureQ && !strobes.flush) |=> ($stable(sampleI) && $stable(sampleQ)));

  // R5
  q_takes_bus_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.captureQ |=> (sampleQ == $past(wordIn)));

endmodule

// File: rtl/iq_port_rx.sv
module iq_port_rx
  import iq_port_pkg::*;
#(
  parameter int WORD_W      = 14,
  parameter int HALF_PERIOD = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txEnable,
  input  logic [WORD_W-1:0] wordIn,
  output logic              dataClkOut,
  output logic [WORD_W-1:0] sampleI,
  output logic [WORD_W-1:0] sampleQ,
  output logic              sampleValid
);

  ctlStrobes_t strobes;

  iq_port_ctrl #(
    .HALF_PERIOD(HALF_PERIOD)
  ) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .txEnable  (txEnable),
    .dataClkOut(dataClkOut),
    .strobes   (strobes)
  );

  iq_port_dpath #(
    .WORD_W(WORD_W)
  ) i_dpath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .wordIn     (wordIn),
    .sampleI    (sampleI),
    .sampleQ    (sampleQ),
    .sampleValid(sampleValid)
  );

  // R6
  valid_from_clock_chk: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> $rose(dataClkOut));

endmodule

// File: tb/test_iq_port_rx.sv
`timescale 1ns/100ps
module test_iq_port_rx;

  localparam int WW   = 14;
  localparam int HALF = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          txEnable = 1'b0;
  logic [WW-1:0] wordIn = '0;
  logic          dataClkOut;
  logic [WW-1:0] sampleI;
  logic [WW-1:0] sampleQ;
  logic          sampleValid;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";

  // Behavioural reference state
  int            edgeCount = 0;
  logic [WW-1:0] pend[$];
  logic [WW-1:0] mI = '0;
  logic [WW-1:0] mQ = '0;
  logic          mV = 1'b0;
  int            validCount = 0;
  int            captureCount = 0;

  always #2.5 clk = !clk;

  iq_port_rx #(.WORD_W(WW), .HALF_PERIOD(HALF)) i_iq_port_rx (
    .clk(clk), .rst(rst), .txEnable(txEnable), .wordIn(wordIn),
    .dataClkOut(dataClkOut), .sampleI(sampleI), .sampleQ(sampleQ),
    .sampleValid(sampleValid)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      edgeCount = 0;
      pend.delete();
      mI = '0; mQ = '0; mV = 1'b0;
    end else begin
      bit rising;
      rising = (edgeCount % HALF == HALF - 1) && ((edgeCount / HALF) % 2 == 0);
      mV = 1'b0;
      if (!txEnable) begin
        pend.delete();
        mI = '0; mQ = '0;
      end else if (rising) begin
        captureCount++;
        if (pend.size() == 0) pend.push_back(wordIn);
        else begin
          mI = pend.pop_front();
          mQ = wordIn;
          mV = 1'b1;
          validCount++;
        end
      end
      edgeCount++;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R2", "dataClkOut", int'(dataClkOut), (edgeCount / HALF) % 2);
      check((mV ? "R5" : curReq), "sampleValid", int'(sampleValid), int'(mV));
      check((mV ? "R4" : curReq), "sampleI", int'(sampleI), int'(mI));
      check((mV ? "R3" : curReq), "sampleQ", int'(sampleQ), int'(mQ));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic step(input logic en, input logic [WW-1:0] w);
    @(negedge clk);
    #1;
    txEnable = en;
    wordIn = w;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1", "dataClkOut in reset", int'(dataClkOut), 0);
    check("R1", "sampleValid in reset", int'(sampleValid), 0);
    check("R1", "sampleI in reset", int'(sampleI), 0);
    check("R1", "sampleQ in reset", int'(sampleQ), 0);
    #1 rst = 1'b0;

    // R3 / R4: counting ramp in one burst
    curReq = "R3";
    for (int k = 0; k < 48; k++) step(1'b1, WW'(k + 100));

    // R7: bursts cut after varying lengths, mid-pair and between pairs
    curReq = "R7";
    for (int n = 1; n <= 12; n++) begin
      for (int k = 0; k < n; k++) step(1'b1, WW'($urandom_range(0, 16383)));
      step(1'b0, WW'($urandom_range(0, 16383)));
    end

    // R8: words with burst inactive are ignored
    curReq = "R8";
    for (int k = 0; k < 24; k++) step(1'b0, WW'($urandom_range(1, 16383)));

    // R6 / R9: long random bursts
    curReq = "R9";
    validCount = 0; captureCount = 0;
    for (int k = 0; k < 200; k++) step(1'b1, WW'($urandom_range(0, 16383)));
    @(negedge clk);
    // R6: one strobe for every two captures
    check("R6", "strobes vs captures", validCount * 2, captureCount - (captureCount % 2));
    check("R6", "strobe count nonzero", int'(validCount > 0), 1);
    for (int k = 0; k < 8; k++) step(1'b0, '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule